// File: doc/BRIEF.md
# Stereo Logarithmic Attenuator with Soft Mute

This block scales a stream of signed stereo sample frames by a gain picked with a 6-bit attenuation code. The code selects a linear factor from a 64-entry table built at elaboration time: the steps are 1 dB apart over most of the range. They widen near the quiet end, and the highest codes silence the output completely. A separate mute request does not cut the signal at once. It walks a ramp factor down by a fixed amount on every frame until the ramp reaches zero. When the request is released, the same walk runs back up to unity. The ramp factor and the table factor are multiplied into one effective gain per frame.

A frame is one left sample and one right sample presented together with `in_valid`. The attenuation code and the mute request are only looked at in a cycle where `in_valid` is high. Both channels of a frame are therefore always scaled by the same gain. Results appear on `out_left`/`out_right` with `out_valid` two clock cycles after the frame is accepted. Between frames the outputs hold their last value.

Top module: `vol_atten_stage`

## Requirements
- R1: A frame accepted in clock cycle k (`in_valid` high at edge k) is presented with `out_valid` high after edge k+1. `out_valid` is low after every edge k+1 whose edge k had `in_valid` low.
- R2: Codes 0 and 1 give a table factor of 32768 (unity in Q1.15). With the ramp at unity, the output equals the input sample exactly.
- R3: A code c in 2..52 gives an attenuation of (c-1) dB, with a table factor of round(32768 * 10^(-(c-1)/20)).
- R4: Codes 53, 54, 55 and 56 give attenuations of 52, 54, 57 and 60 dB respectively, with the table factor computed by the same formula.
- R5: Codes 57 to 63 give a table factor of 0, so both outputs of such a frame are 0.
- R6: The effective gain is eff = (table * ramp + 16384) >> 15. Each output is (sample * eff + 16384) >>> 15 (arithmetic shift), clamped to the 20-bit signed range.
- R7: The code and the mute request have no effect in cycles where `in_valid` is low. The gain of a frame depends only on the values present in its own accept cycle.
- R8: Each accepted frame with mute = 1 uses the current ramp value and then lowers the ramp by RAMP_STEP (default 1024), stopping at 0.
- R9: Each accepted frame with mute = 0 uses the current ramp value and then raises the ramp by RAMP_STEP, stopping at 32768.
- R10: After reset, `out_valid` is 0, both outputs are 0 and the ramp is at 32768 (unmuted).
- R11: The magnitude of an output sample never exceeds the magnitude of the input sample it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stereo frame is presented this cycle |
| in_left | input | DATA_W (20) | Left sample, two's complement |
| in_right | input | DATA_W (20) | Right sample, two's complement |
| vol_code | input | 6 | Attenuation code, sampled with in_valid |
| mute | input | 1 | 1 requests soft mute, 0 releases it; sampled with in_valid |
| out_valid | output | 1 | Scaled frame is present |
| out_left | output | DATA_W (20) | Scaled left sample |
| out_right | output | DATA_W (20) | Scaled right sample |

## Verification
The assertions assume that reset is held low from time zero until the first clock edges have passed. They make no assumption about `vol_code`, `mute` or the sample buses outside accept cycles. The stimulus deliberately scrambles those inputs between frames to show that the ramp and gain hold. The stimulus changes inputs only on the falling clock edge, so every accept cycle sees settled values. It covers every one of the 64 codes, full-scale positive and negative samples, and frames sent back to back as well as with gaps. Mute requests are held long enough for the ramp to reach both of its end stops.

// File: rtl/vol_atten_pkg.sv
package vol_atten_pkg;

   localparam int VOL_CODE_W = 6;
   localparam int GAIN_W     = 16;
   localparam int GAIN_FRAC  = 15;
   localparam int UNITY      = 1 << GAIN_FRAC;
   localparam int ROUND_HALF = 1 << (GAIN_FRAC - 1);

   // attenuation in dB for a code, -1 meaning silence
   function automatic int code_to_db(input int code);
      int db;
      if (code < 2)        db = 0;
      else if (code <= 52) db = code - 1;
      else if (code == 53) db = 52;
      else if (code == 54) db = 54;
      else if (code == 55) db = 57;
      else if (code == 56) db = 60;
      else                 db = -1;
      return db;
   endfunction

   // linear Q1.15 factor for a code, rounded to nearest
   function automatic int code_to_gain(input int code);
      int  db;
      real lin;
      db = code_to_db(code);
      if (db < 0) return 0;
      lin = real'(UNITY) * (10.0 ** (-real'(db) / 20.0));
      return int'(lin);
   endfunction

endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom
   import vol_atten_pkg::*;
#(
   parameter int CODE_W = VOL_CODE_W,
   parameter int OUT_W  = GAIN_W
) (
   input  logic [CODE_W-1:0] code,
   output logic [OUT_W-1:0]  gain
);

   localparam int DEPTH = 1 << CODE_W;

   if (CODE_W != VOL_CODE_W) begin : g_bad_code_w
      $error("vol_gain_rom: CODE_W must equal %0d", VOL_CODE_W);
   end
   if (OUT_W < GAIN_FRAC + 1) begin : g_bad_out_w
      $error("vol_gain_rom: OUT_W too narrow for unity gain");
   end

   logic [OUT_W-1:0] tbl [DEPTH];

   for (genvar c = 0; c < DEPTH; c++) begin : g_entry
      assign tbl[c] = OUT_W'(code_to_gain(c));
   end

   assign gain = tbl[code];

endmodule

// File: rtl/vol_soft_ramp.sv
module vol_soft_ramp
   import vol_atten_pkg::*;
#(
   parameter int STEP = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_en,
   input  logic              mute_req,
   output logic [GAIN_W-1:0] ramp
);

   localparam logic [GAIN_W:0] FULL_X = (GAIN_W+1)'(UNITY);
   localparam logic [GAIN_W:0] STEP_X = (GAIN_W+1)'(STEP);

   if (STEP < 1 || STEP > UNITY) begin : g_bad_step
      $error("vol_soft_ramp: STEP must lie in 1..%0d", UNITY);
   end

   logic [GAIN_W-1:0] ramp_q, ramp_n;
   logic [GAIN_W:0]   up_sum;

   always_comb begin
      up_sum = {1'b0, ramp_q} + STEP_X;
      if (mute_req) begin
         if ({1'b0, ramp_q} > STEP_X) ramp_n = ramp_q - STEP_X[GAIN_W-1:0];
         else                         ramp_n = '0;
      end else begin
         if (up_sum >= FULL_X) ramp_n = FULL_X[GAIN_W-1:0];
         else                  ramp_n = up_sum[GAIN_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ramp_q <= FULL_X[GAIN_W-1:0];
      else if (frame_en) ramp_q <= ramp_n;
   end

   assign ramp = ramp_q;

   // R7: ramp moves only on accepted frames
   assert_ramp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_en |=> $stable(ramp_q));

   // R8: muted frame lowers a nonzero ramp
   assert_ramp_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_en && mute_req && ramp_q != '0) |=> (ramp_q < $past(ramp_q)));

   // R9: unmuted frame raises a ramp below unity
   assert_ramp_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_en && !mute_req && {1'b0, ramp_q} != FULL_X) |=> (ramp_q > $past(ramp_q)));

   // R9: ramp never passes unity
   assert_ramp_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, ramp_q} <= FULL_X);

endmodule

// File: rtl/vol_lane_scale.sv
module vol_lane_scale
   import vol_atten_pkg::*;
#(
   parameter int DATA_W = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic signed [DATA_W-1:0] samp,
   input  logic [GAIN_W-1:0]        gain,
   output logic signed [DATA_W-1:0] result
);

   localparam int PW = DATA_W + GAIN_W + 1;
   localparam logic signed [PW-1:0] HALF = PW'(ROUND_HALF);
   localparam logic signed [PW-1:0] MAXV = PW'((64'(1) << (DATA_W - 1)) - 1);
   localparam logic signed [PW-1:0] MINV = -PW'(64'(1) << (DATA_W - 1));

   logic signed [PW-1:0]     prod, rnd, shf;
   logic signed [DATA_W-1:0] sat_d;

   always_comb begin
      prod = $signed({{(PW-DATA_W){samp[DATA_W-1]}}, samp})
           * $signed({{(PW-GAIN_W){1'b0}}, gain});
      rnd  = prod + HALF;
      shf  = rnd >>> GAIN_FRAC;
      if (shf > MAXV)      sat_d = MAXV[DATA_W-1:0];
      else if (shf < MINV) sat_d = MINV[DATA_W-1:0];
      else                 sat_d = shf[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    result <= '0;
      else if (load) result <= sat_d;
   end

   function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] x);
      logic signed [DATA_W:0] e;
      e = {x[DATA_W-1], x};
      return e[DATA_W] ? (DATA_W+1)'(-e) : (DATA_W+1)'(e);
   endfunction

   // R11: no sample grows in magnitude
   assert_no_growth_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mag(result) <= mag($past(samp))));

endmodule

// File: rtl/vol_atten_stage.sv
module vol_atten_stage
   import vol_atten_pkg::*;
#(
   parameter int DATA_W    = 20,
   parameter int RAMP_STEP = 1024
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic signed [DATA_W-1:0]     in_left,
   input  logic signed [DATA_W-1:0]     in_right,
   input  logic [VOL_CODE_W-1:0]        vol_code,
   input  logic                         mute,
   output logic                         out_valid,
   output logic signed [DATA_W-1:0]     out_left,
   output logic signed [DATA_W-1:0]     out_right
);

   localparam int NCH    = 2;
   localparam int PROD_W = 2 * GAIN_W;

   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_data_w
      $error("vol_atten_stage: DATA_W must lie in 8..32");
   end

   logic [GAIN_W-1:0]        vol_gain, ramp_gain, eff_d, eff_q;
   logic [PROD_W-1:0]        gprod;
   logic                     frame_v;
   logic signed [DATA_W-1:0] samp_d   [NCH];
   logic signed [DATA_W-1:0] samp_q   [NCH];
   logic signed [DATA_W-1:0] lane_out [NCH];

   vol_gain_rom #(
      .CODE_W (VOL_CODE_W),
      .OUT_W  (GAIN_W)
   ) u_rom (
      .code (vol_code),
      .gain (vol_gain)
   );

   vol_soft_ramp #(
      .STEP (RAMP_STEP)
   ) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_en (in_valid),
      .mute_req (mute),
      .ramp     (ramp_gain)
   );

   always_comb begin
      gprod = PROD_W'(vol_gain) * PROD_W'(ramp_gain) + PROD_W'(ROUND_HALF);
      eff_d = GAIN_W'(gprod >> GAIN_FRAC);
   end

   assign samp_d[0] = in_left;
   assign samp_d[1] = in_right;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_v <= 1'b0;
         eff_q   <= '0;
         for (int ch = 0; ch < NCH; ch++) samp_q[ch] <= '0;
      end else begin
         frame_v <= in_valid;
         if (in_valid) begin
            eff_q <= eff_d;
            for (int ch = 0; ch < NCH; ch++) samp_q[ch] <= samp_d[ch];
         end
      end
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
      vol_lane_scale #(
         .DATA_W (DATA_W)
      ) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (frame_v),
         .samp   (samp_q[ch]),
         .gain   (eff_q),
         .result (lane_out[ch])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= frame_v;
   end

   assign out_left  = lane_out[0];
   assign out_right = lane_out[1];

   // R1: accepted frame appears two edges later
   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);

   // R1: no output without a frame two edges earlier
   assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid);

   // R5: silent codes give zero on both lanes
   assert_silent_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vol_code >= VOL_CODE_W'(57)) |=> ##1 (out_left == '0 && out_right == '0));

   // R6: combined gain never exceeds unity
   assert_gain_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_v |-> (eff_q <= GAIN_W'(UNITY)));

endmodule

// File: tb/vol_atten_stage_tb.sv
`timescale 1ns/1ps
module vol_atten_stage_tb;

   localparam int STEP = 1024;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               in_valid;
   logic signed [19:0] in_left, in_right;
   logic [5:0]         vol_code;
   logic               mute;
   logic               out_valid;
   logic signed [19:0] out_left, out_right;

   int    vectors = 0;
   int    fails   = 0;
   int    cycles  = 0;
   bit    run_chk = 0;
   bit    done    = 0;
   string cur_req = "R10";

   always #2.5 clk = ~clk;

   vol_atten_stage #(.DATA_W(20), .RAMP_STEP(STEP)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_left   (in_left),
      .in_right  (in_right),
      .vol_code  (vol_code),
      .mute      (mute),
      .out_valid (out_valid),
      .out_left  (out_left),
      .out_right (out_right)
   );

   // attenuation table from the requirements (R2..R5)
   function automatic longint ref_gain(input int code);
      real db;
      if (code <= 1)       db = 0.0;
      else if (code <= 52) db = real'(code - 1);
      else if (code == 53) db = 52.0;
      else if (code == 54) db = 54.0;
      else if (code == 55) db = 57.0;
      else if (code == 56) db = 60.0;
      else return 0;
      return longint'($floor(32768.0 * $pow(10.0, -db / 20.0) + 0.5));
   endfunction

   function automatic longint scl(input longint s, input longint eff);
      longint t;
      t = (s * eff + 16384) >>> 15;
      if (t > 524287)  t = 524287;
      if (t < -524288) t = -524288;
      return t;
   endfunction

   // behavioural reference, advanced on every rising edge
   longint mr, g, eff;
   bit     s_v, e_v;
   longint s_l, s_r, e_l, e_r;

   always @(posedge clk) begin
      if (!rst_n) begin
         mr = 32768; s_v = 0; e_v = 0;
         s_l = 0; s_r = 0; e_l = 0; e_r = 0;
      end else begin
         e_v = s_v; e_l = s_l; e_r = s_r;
         s_v = in_valid;
         if (in_valid) begin
            g   = ref_gain(int'(vol_code));
            eff = (g * mr + 16384) >>> 15;
            s_l = scl(longint'(in_left), eff);
            s_r = scl(longint'(in_right), eff);
            if (mute) mr = (mr > STEP) ? mr - STEP : 0;
            else      mr = (mr + STEP >= 32768) ? 32768 : mr + STEP;
         end
      end
   end

   task automatic report(input string what, input longint act, input longint exp);
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
   endtask

   // compare on every clock, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && run_chk && !done) begin
         vectors++;
         if (out_valid !== e_v) report("out_valid", longint'(out_valid), longint'(e_v));
         else if (e_v) begin
            if (longint'(out_left) != e_l)  report("out_left", longint'(out_left), e_l);
            if (longint'(out_right) != e_r) report("out_right", longint'(out_right), e_r);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   function automatic logic signed [19:0] rs();
      return 20'($urandom);
   endfunction

   task automatic frame(input int code, input bit m, input logic signed [19:0] l,
                        input logic signed [19:0] r, input int gap, input bit scr);
      @(negedge clk);
      in_valid = 1'b1;
      vol_code = 6'(code);
      mute     = m;
      in_left  = l;
      in_right = r;
      for (int i = 0; i < gap; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         if (scr) begin
            vol_code = 6'($urandom);
            mute     = 1'($urandom);
            in_left  = rs();
            in_right = rs();
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
      vol_code = '0; mute = 1'b0;
      repeat (4) @(negedge clk);
      // R10: reset state at the ports
      vectors++;
      if (out_valid !== 1'b0) report("reset out_valid", longint'(out_valid), 0);
      vectors++;
      if (out_left !== '0 || out_right !== '0) report("reset data", longint'(out_left), 0);
      rst_n   = 1'b1;
      run_chk = 1;

      cur_req = "R10";   // ramp at unity right after reset
      frame(0, 0, 20'sd300000, -20'sd300000, 1, 0);

      cur_req = "R2";
      for (int i = 0; i < 8; i++) frame(i % 2, 0, rs(), rs(), i % 3, 0);

      cur_req = "R3";
      for (int c = 2; c <= 52; c++)
         for (int k = 0; k < 2; k++) frame(c, 0, rs(), rs(), k, 0);

      cur_req = "R4";
      for (int c = 53; c <= 56; c++)
         for (int k = 0; k < 3; k++) frame(c, 0, rs(), rs(), k, 0);

      cur_req = "R5";
      for (int c = 57; c <= 63; c++)
         for (int k = 0; k < 2; k++) frame(c, 0, rs(), rs(), k, 0);

      cur_req = "R11";
      for (int c = 0; c < 64; c++) begin
         frame(c, 0, 20'sd524287, -20'sd524288, 0, 0);
         frame(c, 0, -20'sd524288, 20'sd524287, 1, 0);
      end

      cur_req = "R7";
      for (int i = 0; i < 30; i++) frame(int'($urandom % 64), 0, rs(), rs(), 1 + i % 4, 1);

      cur_req = "R1";
      for (int i = 0; i < 10; i++) frame(i, 0, rs(), rs(), 0, 0);
      for (int i = 0; i < 6; i++)  frame(i + 10, 0, rs(), rs(), 5, 0);

      cur_req = "R8";
      for (int i = 0; i < 40; i++) frame(0, 1, 20'sd524287, -20'sd524288, i % 2, 0);

      cur_req = "R9";
      for (int i = 0; i < 40; i++) frame(0, 0, 20'sd524287, -20'sd524288, i % 3, 0);

      cur_req = "R6";
      for (int i = 0; i < 120; i++)
         frame(int'($urandom % 57), ((i / 7) % 2) == 1, rs(), rs(), i % 2, 0);

      @(negedge clk);
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule